// File: doc/BRIEF.md
# Multi-Processor Interrupt Router

This block is a shared interrupt router for a cluster of virtual processors. It takes `NUM_IRQ` level-sensitive external sources and sends each one to a single output pin of a single processor. Every source carries four pieces of state: a pending bit, an enable bit, a pin selection and a processor selection. The pending bit follows the source input. Software can also force it through a wedge register. Each processor also has a local compare request input, which the block merges into one of that processor's pins.

Software reaches the block through a simple word-addressed register bus. A two-state bus controller handles it. In state IDLE, `bus_ready` is high and a write is applied at the clock edge that accepts it. A read request in IDLE captures the addressed word at that same edge. The transition IDLE to RDATA fires on a read request. In RDATA, `bus_rdata` is valid with `bus_rvalid` high and `bus_ready` low. The transition RDATA to IDLE is unconditional and takes one cycle. Every output pin is a register. An input change, or a write, that is sampled at a clock edge shows on `pin_out` at that same edge. `NUM_IRQ` must be a multiple of 8 and no larger than 256.

Top module: `irq_router`

## Requirements
- R1: Each time `irq_in[i]` changes level, source i's pending bit takes the new level. This happens whether or not the source is enabled. The pending bitmap is read at word address 0x040+k, where bit b is source 32k+b.
- R2: A source whose enable bit is 0 contributes to no output pin, even while it is pending.
- R3: In a write to word address 0x080+k, each 1 bit enables source 32k+b. In a write to 0x0A0+k, each 1 bit disables it. Zero bits in either write leave enables unchanged. The enable bitmap is read at 0x060+k.
- R4: A write to 0x001 is a wedge write. Bit 31 = 1 sets the pending bit of the source numbered in bits [30:0], and bit 31 = 0 clears it. A number at or above `NUM_IRQ` is ignored. A wedge wins over an input change on the same source in the same cycle.
- R5: A write to 0x200+i carries a one-hot processor vector. The index of its lowest set bit is stored if it is below `NUM_VP`; a higher index is ignored. All zeros unmaps the source. A read returns 1 shifted left by the stored index, or 0 when the source is unmapped. An unmapped source drives no pin.
- R6: The pin map of source i is at 0x100+i. Bit 31 is a map-to-pin flag and bits [30:0] are the pin number. A write whose pin number exceeds `NUM_PIN`-1 is ignored. A read returns the flag in bit 31 and the pin in the low bits.
- R7: `pin_out[v*NUM_PIN+p]` is the OR of every enabled, pending source mapped to processor v and pin p, plus the processor's compare term.
- R8: The local compare word of processor v is at 0x300+v. Bit 31 is a map-to-pin flag, bit 30 is the compare enable, and bits [29:0] are the pin. A write whose pin exceeds `NUM_PIN`-1 is ignored. When the compare enable is set, `cmp_pend[v]` drives the selected pin.
- R9: After reset, every source has enable 0, pending 0, a pin map of 0x8000_0000 and no processor. Each compare word is 0xC000_0000 and all pins are low.
- R10: The configuration word at 0x000 holds `NUM_IRQ`/8-1 in bits [23:16] and `NUM_VP` in bits [7:0]. All its other bits are zero.
- R11: Writes to a source number at or above `NUM_IRQ` are ignored. Reads of such a source, and bitmap bits past the last source, return 0.
- R12: A read accepted in IDLE returns its data in the next cycle, with `bus_rvalid` high and `bus_ready` low for exactly that one cycle. A change sampled at a clock edge appears on `pin_out` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Controller can accept a request |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq_in | input | NUM_IRQ | External source levels |
| cmp_pend | input | NUM_VP | Local compare request per processor |
| pin_out | output | NUM_VP*NUM_PIN | Processor pins, processor v pin p at bit v*NUM_PIN+p |

## Verification
The bench first gives every source a distinct processor and pin pair. It then raises one source at a time. This sweep separates a misrouted pin or processor from a missing OR term. Next it raises all sources with alternating enables, which shows whether disabled sources leak onto pins while their pending bits still follow the inputs. Wedge writes with numbers inside and outside the range tell software control of the pending bit apart from input tracking. Out-of-range pin, processor and source writes, together with toggling of the compare inputs, confirm that ignored writes leave readable state and pins untouched.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } bus_state_e;

    // word addresses of the register groups
    localparam logic [31:0] A_CONFIG = 32'h000;
    localparam logic [31:0] A_WEDGE  = 32'h001;
    localparam logic [31:0] A_PEND   = 32'h040;
    localparam logic [31:0] A_MASK   = 32'h060;
    localparam logic [31:0] A_SETM   = 32'h080;
    localparam logic [31:0] A_CLRM   = 32'h0A0;
    localparam logic [31:0] A_PINMAP = 32'h100;
    localparam logic [31:0] A_VPMAP  = 32'h200;
    localparam logic [31:0] A_CMP    = 32'h300;

    localparam int CFG_IRQ_LSB = 16;

    // index of the lowest set bit (0 when the vector is empty)
    function automatic logic [5:0] lowest_set(input logic [31:0] v);
        logic [5:0] idx;
        idx = '0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) idx = 6'(k);
        end
        return idx;
    endfunction

endpackage

// File: rtl/rtr_bus_ctl.sv
module rtr_bus_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] rd_word,
    output logic        ready,
    output logic        rvalid,
    output logic        wr_en,
    output logic [31:0] rdata
);
    import rtr_pkg::*;

    bus_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req && !we) st_d = ST_RDATA;
            ST_RDATA: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        rvalid = 1'b0;
        wr_en  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ready = 1'b1;
                wr_en = req && we;
            end
            ST_RDATA: rvalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            rdata <= '0;
        else if (st_q == ST_IDLE && req && !we) rdata <= rd_word;
    end

    // R12: read data only follows an accepted read
    a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req && !we));
    // R12: read data valid for a single cycle
    a_r12_single_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/rtr_src_bank.sv
module rtr_src_bank #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    localparam int PINW   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int VPW    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [31:0]              addr,
    input  logic [31:0]              wdata,
    input  logic [NUM_IRQ-1:0]       irq_in,
    output logic [NUM_IRQ-1:0]       pend_nx,
    output logic [NUM_IRQ-1:0]       en_nx,
    output logic [NUM_IRQ-1:0]       vpv_nx,
    output logic [NUM_IRQ*VPW-1:0]   vpi_nx,
    output logic [NUM_IRQ*PINW-1:0]  pin_nx,
    output logic [31:0]              rd_word
);
    import rtr_pkg::*;

    localparam int NWORDS = (NUM_IRQ + 31) / 32;

    logic [NUM_IRQ-1:0]      pend_cur, en_cur, vpv_cur, flag_cur;
    logic [NUM_IRQ*PINW-1:0] pin_cur;
    logic [NUM_IRQ*VPW-1:0]  vpi_cur;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        localparam int WORD = i / 32;
        localparam int BITP = i % 32;

        logic            prev_q, pend_q, en_q, flag_q, vpv_q;
        logic [PINW-1:0] pin_q;
        logic [VPW-1:0]  vpi_q;
        logic            pend_d, en_d, flag_d, vpv_d;
        logic [PINW-1:0] pin_d;
        logic [VPW-1:0]  vpi_d;
        logic            wedge_hit, set_hit, clr_hit, pin_hit, vp_hit;
        logic            pin_ok, vp_zero, vp_ok;
        logic [5:0]      low_idx;

        always_comb begin
            wedge_hit = wr_en && (addr == A_WEDGE) && ({1'b0, wdata[30:0]} == 32'(i));
            set_hit   = wr_en && (addr == A_SETM + 32'(WORD)) && wdata[BITP];
            clr_hit   = wr_en && (addr == A_CLRM + 32'(WORD)) && wdata[BITP];
            pin_hit   = wr_en && (addr == A_PINMAP + 32'(i));
            vp_hit    = wr_en && (addr == A_VPMAP + 32'(i));
            pin_ok    = ({1'b0, wdata[30:0]} <= 32'(NUM_PIN - 1));
            low_idx   = lowest_set(wdata);
            vp_zero   = (wdata == '0);
            vp_ok     = vp_zero || (32'(low_idx) < 32'(NUM_VP));

            // wedge first, then level tracking
            if (wedge_hit)             pend_d = wdata[31];
            else if (irq_in[i] != prev_q) pend_d = irq_in[i];
            else                       pend_d = pend_q;

            if (set_hit)      en_d = 1'b1;
            else if (clr_hit) en_d = 1'b0;
            else              en_d = en_q;

            flag_d = flag_q;
            pin_d  = pin_q;
            if (pin_hit && pin_ok) begin
                flag_d = wdata[31];
                pin_d  = wdata[PINW-1:0];
            end

            vpv_d = vpv_q;
            vpi_d = vpi_q;
            if (vp_hit && vp_ok) begin
                vpv_d = !vp_zero;
                vpi_d = vp_zero ? '0 : low_idx[VPW-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                en_q   <= 1'b0;
                flag_q <= 1'b1;
                pin_q  <= '0;
                vpv_q  <= 1'b0;
                vpi_q  <= '0;
            end else begin
                prev_q <= irq_in[i];
                pend_q <= pend_d;
                en_q   <= en_d;
                flag_q <= flag_d;
                pin_q  <= pin_d;
                vpv_q  <= vpv_d;
                vpi_q  <= vpi_d;
            end
        end

        assign pend_nx[i]                 = pend_d;
        assign en_nx[i]                   = en_d;
        assign vpv_nx[i]                  = vpv_d;
        assign vpi_nx[i*VPW +: VPW]       = vpi_d;
        assign pin_nx[i*PINW +: PINW]     = pin_d;
        assign pend_cur[i]                = pend_q;
        assign en_cur[i]                  = en_q;
        assign vpv_cur[i]                 = vpv_q;
        assign flag_cur[i]                = flag_q;
        assign vpi_cur[i*VPW +: VPW]      = vpi_q;
        assign pin_cur[i*PINW +: PINW]    = pin_q;

        // R1: pending takes the new input level after a change
        a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past((irq_in[i] != prev_q) && !wedge_hit))
            |-> (pend_q == $past(irq_in[i])));
        // R6: out-of-range pin write leaves the map alone
        a_r6_pin_ignore: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pin_hit && !pin_ok)) |-> (pin_q == $past(pin_q)));
    end

    // R3: enables only move on a bus write
    a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(en_cur));

    logic [NWORDS*32-1:0] pend_pad, en_pad;

    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        pend_pad[NUM_IRQ-1:0] = pend_cur;
        en_pad[NUM_IRQ-1:0]   = en_cur;
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (addr == A_PEND + 32'(k)) rd_word = pend_pad[k*32 +: 32];
            if (addr == A_MASK + 32'(k)) rd_word = en_pad[k*32 +: 32];
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (addr == A_PINMAP + 32'(i))
                rd_word = {flag_cur[i], {(31-PINW){1'b0}}, pin_cur[i*PINW +: PINW]};
            if (addr == A_VPMAP + 32'(i))
                rd_word = vpv_cur[i] ? (32'd1 << vpi_cur[i*VPW +: VPW]) : 32'd0;
        end
    end

endmodule

// File: rtl/rtr_pin_merge.sv
module rtr_pin_merge #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    localparam int PINW   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int VPW    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [31:0]              addr,
    input  logic [31:0]              wdata,
    input  logic [NUM_VP-1:0]        cmp_pend,
    input  logic [NUM_IRQ-1:0]       src_pend_nx,
    input  logic [NUM_IRQ-1:0]       src_en_nx,
    input  logic [NUM_IRQ-1:0]       src_vpv_nx,
    input  logic [NUM_IRQ*VPW-1:0]   src_vpi_nx,
    input  logic [NUM_IRQ*PINW-1:0]  src_pin_nx,
    output logic [NUM_VP*NUM_PIN-1:0] pin_out,
    output logic [31:0]              rd_word
);
    import rtr_pkg::*;

    logic [NUM_VP-1:0]      cmp_en_d, cmp_en_q, cmp_flag_q;
    logic [NUM_VP*PINW-1:0] cmp_pin_d, cmp_pin_q;

    for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
        logic            hit, ok, flag_q, en_q, flag_d, en_d;
        logic [PINW-1:0] pin_q, pin_d;

        always_comb begin
            hit    = wr_en && (addr == A_CMP + 32'(v));
            ok     = ({2'b00, wdata[29:0]} <= 32'(NUM_PIN - 1));
            flag_d = flag_q;
            en_d   = en_q;
            pin_d  = pin_q;
            if (hit && ok) begin
                flag_d = wdata[31];
                en_d   = wdata[30];
                pin_d  = wdata[PINW-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b1;
                en_q   <= 1'b1;
                pin_q  <= '0;
            end else begin
                flag_q <= flag_d;
                en_q   <= en_d;
                pin_q  <= pin_d;
            end
        end

        assign cmp_en_d[v]                = en_d;
        assign cmp_pin_d[v*PINW +: PINW]  = pin_d;
        assign cmp_en_q[v]                = en_q;
        assign cmp_flag_q[v]              = flag_q;
        assign cmp_pin_q[v*PINW +: PINW]  = pin_q;
    end

    logic [NUM_VP*NUM_PIN-1:0] pin_d, pin_q;

    always_comb begin
        pin_d = '0;
        for (int v = 0; v < NUM_VP; v++) begin
            for (int p = 0; p < NUM_PIN; p++) begin
                if (cmp_en_d[v] && cmp_pend[v] && (cmp_pin_d[v*PINW +: PINW] == PINW'(p)))
                    pin_d[v*NUM_PIN + p] = 1'b1;
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (src_en_nx[i] && src_pend_nx[i] && src_vpv_nx[i] &&
                        (src_vpi_nx[i*VPW +: VPW] == VPW'(v)) &&
                        (src_pin_nx[i*PINW +: PINW] == PINW'(p)))
                        pin_d[v*NUM_PIN + p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign pin_out = pin_q;

    always_comb begin
        rd_word = '0;
        for (int v = 0; v < NUM_VP; v++) begin
            if (addr == A_CMP + 32'(v))
                rd_word = {cmp_flag_q[v], cmp_en_q[v], {(30-PINW){1'b0}}, cmp_pin_q[v*PINW +: PINW]};
        end
    end

    // R7: no active contributor in the sampled cycle means all pins low
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(((src_en_nx & src_pend_nx) == '0) && ((cmp_en_d & cmp_pend) == '0)))
        |-> (pin_q == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 6,
    parameter int ADDR_W  = 10,
    localparam int PINW   = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1,
    localparam int VPW    = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic                      bus_ready,
    output logic                      bus_rvalid,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_IRQ-1:0]        irq_in,
    input  logic [NUM_VP-1:0]         cmp_pend,
    output logic [NUM_VP*NUM_PIN-1:0] pin_out
);
    import rtr_pkg::*;

    logic [31:0] addr32, cfg_word, bank_rd, merge_rd, rd_word;
    logic        wr_en;

    logic [NUM_IRQ-1:0]      pend_nx, en_nx, vpv_nx;
    logic [NUM_IRQ*VPW-1:0]  vpi_nx;
    logic [NUM_IRQ*PINW-1:0] pin_nx;

    assign addr32   = 32'(bus_addr);
    assign cfg_word = (32'(NUM_IRQ / 8 - 1) << CFG_IRQ_LSB) | 32'(NUM_VP);
    assign rd_word  = ((addr32 == A_CONFIG) ? cfg_word : 32'd0) | bank_rd | merge_rd;

    rtr_bus_ctl u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .rd_word (rd_word),
        .ready   (bus_ready),
        .rvalid  (bus_rvalid),
        .wr_en   (wr_en),
        .rdata   (bus_rdata)
    );

    rtr_src_bank #(.NUM_IRQ(NUM_IRQ), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr32),
        .wdata   (bus_wdata),
        .irq_in  (irq_in),
        .pend_nx (pend_nx),
        .en_nx   (en_nx),
        .vpv_nx  (vpv_nx),
        .vpi_nx  (vpi_nx),
        .pin_nx  (pin_nx),
        .rd_word (bank_rd)
    );

    rtr_pin_merge #(.NUM_IRQ(NUM_IRQ), .NUM_VP(NUM_VP), .NUM_PIN(NUM_PIN)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr32),
        .wdata       (bus_wdata),
        .cmp_pend    (cmp_pend),
        .src_pend_nx (pend_nx),
        .src_en_nx   (en_nx),
        .src_vpv_nx  (vpv_nx),
        .src_vpi_nx  (vpi_nx),
        .src_pin_nx  (pin_nx),
        .pin_out     (pin_out),
        .rd_word     (merge_rd)
    );

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
    localparam int NI = 40;
    localparam int NV = 3;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NI-1:0] irq_in = '0;
    logic [NV-1:0] cmp_pend = '0;
    logic [NV*NP-1:0] pin_out;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    // requirement-level model
    bit m_pend[NI], m_en[NI], m_flag[NI], m_vpv[NI];
    int m_pin[NI], m_vpi[NI];
    bit c_flag[NV], c_en[NV];
    int c_pin[NV];

    always #2.5 clk = ~clk;

    irq_router #(.NUM_IRQ(NI), .NUM_VP(NV), .NUM_PIN(NP), .ADDR_W(10)) i_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .cmp_pend(cmp_pend), .pin_out(pin_out)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < NI; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_flag[i] = 1; m_vpv[i] = 0; m_pin[i] = 0; m_vpi[i] = 0;
        end
        for (int v = 0; v < NV; v++) begin
            c_flag[v] = 1; c_en[v] = 1; c_pin[v] = 0;
        end
    endfunction

    function automatic void mdl_write(input int a, input logic [31:0] d);
        if (a == 'h001) begin
            if (d[30:0] < NI) m_pend[d[30:0]] = d[31];
        end else if (a >= 'h080 && a < 'h082) begin
            for (int b = 0; b < 32; b++)
                if (d[b] && (a - 'h080) * 32 + b < NI) m_en[(a - 'h080) * 32 + b] = 1;
        end else if (a >= 'h0A0 && a < 'h0A2) begin
            for (int b = 0; b < 32; b++)
                if (d[b] && (a - 'h0A0) * 32 + b < NI) m_en[(a - 'h0A0) * 32 + b] = 0;
        end else if (a >= 'h100 && a < 'h100 + NI) begin
            if (d[30:0] <= NP - 1) begin
                m_flag[a - 'h100] = d[31]; m_pin[a - 'h100] = int'(d[30:0]);
            end
        end else if (a >= 'h200 && a < 'h200 + NI) begin
            if (d == 0) m_vpv[a - 'h200] = 0;
            else begin
                int lo = 0;
                for (int k = 31; k >= 0; k--) if (d[k]) lo = k;
                if (lo < NV) begin m_vpv[a - 'h200] = 1; m_vpi[a - 'h200] = lo; end
            end
        end else if (a >= 'h300 && a < 'h300 + NV) begin
            if (d[29:0] <= NP - 1) begin
                c_flag[a - 'h300] = d[31]; c_en[a - 'h300] = d[30]; c_pin[a - 'h300] = int'(d[29:0]);
            end
        end
    endfunction

    function automatic logic [31:0] mdl_read(input int a);
        logic [31:0] r = '0;
        if (a == 'h000) r = ((NI / 8 - 1) << 16) | NV;
        else if (a >= 'h040 && a < 'h042) begin
            for (int b = 0; b < 32; b++) if ((a - 'h040) * 32 + b < NI) r[b] = m_pend[(a - 'h040) * 32 + b];
        end else if (a >= 'h060 && a < 'h062) begin
            for (int b = 0; b < 32; b++) if ((a - 'h060) * 32 + b < NI) r[b] = m_en[(a - 'h060) * 32 + b];
        end else if (a >= 'h100 && a < 'h100 + NI) r = {m_flag[a - 'h100], 31'(m_pin[a - 'h100])};
        else if (a >= 'h200 && a < 'h200 + NI) r = m_vpv[a - 'h200] ? (32'd1 << m_vpi[a - 'h200]) : 32'd0;
        else if (a >= 'h300 && a < 'h300 + NV) r = {c_flag[a - 'h300], c_en[a - 'h300], 30'(c_pin[a - 'h300])};
        return r;
    endfunction

    function automatic logic [31:0] exp_pins();
        logic [31:0] e = '0;
        for (int v = 0; v < NV; v++)
            if (c_en[v] && cmp_pend[v]) e[v * NP + c_pin[v]] = 1'b1;
        for (int i = 0; i < NI; i++)
            if (m_en[i] && m_pend[i] && m_vpv[i]) e[m_vpi[i] * NP + m_pin[i]] = 1'b1;
        return e;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        tick();
        bus_req = 1'b0; bus_we = 1'b0;
        mdl_write(a, d);
    endtask

    task automatic check_rd(input string tag, input int a);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 10'(a);
        tick();
        bus_req = 1'b0;
        check("R12", "rvalid", 32'(bus_rvalid), 32'd1);
        check(tag, $sformatf("read 0x%03h", a), bus_rdata, mdl_read(a));
        tick();
    endtask

    task automatic check_pins(input string tag);
        check(tag, "pin_out", 32'(pin_out), exp_pins());
    endtask

    task automatic drive_irq(input logic [NI-1:0] nv);
        for (int i = 0; i < NI; i++) if (nv[i] != irq_in[i]) m_pend[i] = nv[i];
        irq_in = nv;
        tick();
    endtask

    initial begin
        #750000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R9: reset state
        check("R9", "pins after reset", 32'(pin_out), 32'd0);
        check("R12", "ready in idle", 32'(bus_ready), 32'd1);
        check("R12", "rvalid in idle", 32'(bus_rvalid), 32'd0);
        check_rd("R10", 'h000);
        check_rd("R9", 'h040);
        check_rd("R9", 'h060);
        check_rd("R9", 'h100);
        check_rd("R9", 'h100 + NI - 1);
        check_rd("R9", 'h200);
        check_rd("R8", 'h300);
        // R12: ready low while read data is presented
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 10'h000;
        tick();
        bus_req = 1'b0;
        check("R12", "ready during read data", 32'(bus_ready), 32'd0);
        tick();
        check("R12", "single rvalid", 32'(bus_rvalid), 32'd0);

        // R5 R6: map sweep with distinct routes
        for (int i = 0; i < NI; i++) begin
            bus_wr('h100 + i, 32'h8000_0000 | 32'(i % NP));
            bus_wr('h200 + i, 32'd1 << (i % NV));
            check_rd("R6", 'h100 + i);
            check_rd("R5", 'h200 + i);
        end
        // R3 R11: enable all, bits past the last source stay zero
        bus_wr('h080, 32'hFFFF_FFFF);
        bus_wr('h081, 32'hFFFF_FFFF);
        check_rd("R3", 'h060);
        check_rd("R11", 'h061);

        // R7 R12: one source at a time
        for (int i = 0; i < NI; i++) begin
            drive_irq(NI'(1) << i);
            check_pins("R7");
            check_rd("R1", 'h040 + i / 32);
            drive_irq('0);
            check_pins("R7");
        end

        // R2 R1: odd sources disabled, all inputs high
        bus_wr('h0A0, 32'hAAAA_AAAA);
        bus_wr('h0A1, 32'h0000_00AA);
        check_rd("R3", 'h060);
        check_rd("R3", 'h061);
        drive_irq('1);
        check_pins("R2");
        check_rd("R1", 'h040);
        check_rd("R11", 'h041);
        // R3: zero bits leave other enables alone
        bus_wr('h080, 32'h0000_0002);
        check_rd("R3", 'h060);
        check_pins("R3");
        drive_irq('0);
        check_pins("R2");

        // R4: wedge control
        bus_wr('h001, 32'h8000_0004);
        check_pins("R4");
        check_rd("R4", 'h040);
        bus_wr('h001, 32'h8000_0000 | NI);
        bus_wr('h001, 32'hFFFF_FFFF);
        check_rd("R4", 'h040);
        check_rd("R4", 'h041);
        check_pins("R4");
        bus_wr('h001, 32'h0000_0004);
        check_pins("R4");
        check_rd("R4", 'h040);

        // R6 R11: ignored pin and source writes
        bus_wr('h100 + 3, 32'h0000_0006);
        check_rd("R6", 'h100 + 3);
        bus_wr('h100 + 3, 32'h0001_0002);
        check_rd("R6", 'h100 + 3);
        bus_wr('h100 + NI, 32'h0000_0001);
        check_rd("R11", 'h100 + NI);
        check_rd("R11", 'h200 + NI);

        // R5: one-hot lowest bit, high index ignored, zero unmaps
        bus_wr('h200 + 4, 32'h0000_0006);
        check_rd("R5", 'h200 + 4);
        bus_wr('h200 + 4, 32'h0000_0008);
        check_rd("R5", 'h200 + 4);
        drive_irq(NI'(1) << 4);
        check_pins("R5");
        bus_wr('h200 + 4, 32'h0000_0000);
        check_rd("R5", 'h200 + 4);
        check_pins("R5");
        drive_irq('0);

        // R8: local compare requests
        cmp_pend = 3'b111;
        tick();
        check_pins("R8");
        bus_wr('h300 + 1, 32'h4000_0004);
        check_pins("R8");
        check_rd("R8", 'h301);
        bus_wr('h300 + 2, 32'h8000_0003);
        check_pins("R8");
        bus_wr('h300, 32'hC000_0007);
        check_rd("R8", 'h300);
        cmp_pend = 3'b010;
        tick();
        check_pins("R8");
        cmp_pend = 3'b000;
        tick();
        check_pins("R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule